// File: doc/BRIEF.md
# TDM Network-Mode Serial Transmitter

This block sends 24-bit words onto one serial data pin in a time-division-multiplexed frame. A host places a word in a write-only data register. At the start of each enabled time slot the word is copied into a shift register and sent MSB first, one bit per bit-clock tick. A per-slot mask sets which of up to 32 slots carry data. The pin is released (output enable low) in every slot whose mask bit is clear. A separate null register lets the host silence only the next active slot while keeping the same consume-and-refill rhythm as a data write.

The word length per slot is programmable as 8, 12, 16 or 24 bits. An alignment control picks where the MSB is taken from inside the 24-bit register. The block has a simple synchronous register port, an external bit-tick enable and frame-sync input, the serial data and its enable, and a level interrupt that shows the data register is empty.

Top module: `tdm_net_tx`

## Requirements
- R1: After reset, sdOe and irq are 0, the config register reads 0, the mask registers read 0, and the status register reads 0x000001 (bit 0 = empty set, bit 1 = underrun clear).
- R2: Register addresses are: 0 data (write-only, reads 0), 1 null (write-only, reads 0), 2 mask for slots 0..15, 3 mask for slots 16..31, 4 config, 5 status. A mask read returns the 16 stored bits in bits 15:0 and zero in bits 23:16, whatever was written to the upper bits.
- R3: A write to the data or null register clears the status empty bit exactly two clock cycles after the write cycle. Reads in the two cycles that follow the write still show empty set.
- R4: With the block enabled, a bitTick that has frameSync high starts slot 0. The first bit appears on sdOut/sdOe in the clock after that tick. After that, one bit is shifted out per bitTick, MSB first, and slots follow one another. At the tick after the last bit of slot lastSlot, sdOe goes low and stays low until the next frameSync tick. Outputs change only on a clock that sampled bitTick high or a disabled block.
- R5: Config bits 2:1 select the word length: 0 = 8, 1 = 12, 2 = 16, 3 = 24 bits.
- R6: Config bit 3 (align) clear takes the word MSB from data bit 23. When set, it takes it from bit 15. For a 24-bit word length the align bit has no effect.
- R7: A slot whose mask bit is set drives sdOe high for its whole length and consumes the pending word, which sets empty. A slot whose mask bit is clear keeps sdOe low and leaves the pending word and the empty bit untouched.
- R8: After a null register write, the next slot with its mask bit set keeps sdOe low for its whole length and sets empty as if a word had been sent.
- R9: irq equals config bit 4 (interrupt enable) ANDed with the status empty bit.
- R10: If a masked-in slot starts while empty is set, status bit 1 (underrun) is set and the previously sent word is sent again in that slot.
- R11: Underrun is cleared only by a status read that sees it set, followed by a data or null write (two cycles later). A write with no such read before it leaves underrun set.
- R12: With config bit 0 (enable) clear, sdOe is low from the next clock on, and frameSync ticks start nothing.
- R13: Config bits 9:5 hold the index of the last slot in a frame (0..31). Slots 16..31 are governed by the second mask register, bit n-16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (marks a status read) |
| regAddr | input | 3 | Register address |
| regWrData | input | 24 | Register write data |
| regRdData | output | 24 | Register read data (combinational on regAddr) |
| bitTick | input | 1 | One-cycle pulse per serial bit period |
| frameSync | input | 1 | Frame start, sampled with bitTick |
| sdOut | output | 1 | Serial data |
| sdOe | output | 1 | Serial data output enable (low = high impedance) |
| irq | output | 1 | Transmit-empty interrupt, level |

## Verification
The serial path is tried with distinct bit patterns at every word length (0xA5 and 0x3C at 8 bits, 0xABC at 12 bits with the MSB at bit 15, 0xBEEF at 16 bits, and a full 24-bit word with the align bit set). Each pattern has a different value in the bits just below the chosen field, so a wrong length or alignment shows up in the captured word. Frames mix masked-in, masked-out, null-silenced and underrun slots. This separates a slot that consumes the word, one that keeps it, and one that repeats the previous word. A 17-slot frame with only slot 16 enabled shows the second mask bank from the first, and a status-read/write ordering test shows the underrun clear from a plain write.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_DATA    = 3'd0,
    ADDR_NULL    = 3'd1,
    ADDR_MASK_LO = 3'd2,
    ADDR_MASK_HI = 3'd3,
    ADDR_CFG     = 3'd4,
    ADDR_STATUS  = 3'd5
  } regAddrE;

  typedef enum logic [1:0] {
    LEN_8  = 2'd0,
    LEN_12 = 2'd1,
    LEN_16 = 2'd2,
    LEN_24 = 2'd3
  } wordLenE;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic loadNew;    // copy aligned holding word into shifter
    logic reloadLast; // resend the previous word (underrun)
    logic shiftBit;   // advance one bit
    logic driveOn;    // enable the pin for this slot
    logic driveOff;   // release the pin
  } dpStrobeT;

endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int MASK_W    = 16,
  parameter int MAX_SLOTS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [MASK_W-1:0] wrLow,
  output logic [DATA_W-1:0] regRdData,
  input  logic              bitTick,
  input  logic              frameSync,
  output dpStrobeT          strobe,
  output logic              holdWr,
  output logic              cfgEn,
  output logic              cfgIrqEn,
  output logic              cfgAlign,
  output wordLenE           cfgLen,
  output logic              emptyFlag,
  output logic              underrunFlag,
  output logic              irq
);

  localparam int NUM_BANKS = MAX_SLOTS / MASK_W;
  localparam int SLOT_W    = $clog2(MAX_SLOTS);
  localparam int BIT_W     = $clog2(DATA_W);
  localparam int SLOT_LSB  = 5;

  function automatic logic [BIT_W-1:0] lastBitOf(input wordLenE len);
    case (len)
      LEN_8:   return BIT_W'(7);
      LEN_12:  return BIT_W'(11);
      LEN_16:  return BIT_W'(15);
      default: return BIT_W'(23);
    endcase
  endfunction

  // ---------------- register decode ----------------
  logic dataWr, nullWr, anyWr, cfgWr, statusRd;
  assign dataWr   = regWrEn && (regAddr == ADDR_DATA);
  assign nullWr   = regWrEn && (regAddr == ADDR_NULL);
  assign anyWr    = dataWr || nullWr;
  assign cfgWr    = regWrEn && (regAddr == ADDR_CFG);
  assign statusRd = regRdEn && (regAddr == ADDR_STATUS);
  assign holdWr   = dataWr;

  logic [NUM_BANKS-1:0] bankHit;
  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBankSel
    assign bankHit[b] = regWrEn &&
                        (regAddr == ADDR_W'(int'(ADDR_MASK_LO) + b));
  end

  logic [NUM_BANKS-1:0][MASK_W-1:0] maskBank;
  logic [MAX_SLOTS-1:0]             maskFlat;
  assign maskFlat = maskBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskBank <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bankHit[b]) maskBank[b] <= wrLow;
      end
    end
  end

  logic [SLOT_W-1:0] cfgLastSlot;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn       <= 1'b0;
      cfgLen      <= LEN_8;
      cfgAlign    <= 1'b0;
      cfgIrqEn    <= 1'b0;
      cfgLastSlot <= '0;
    end else if (cfgWr) begin
      cfgEn       <= wrLow[0];
      cfgLen      <= wordLenE'(wrLow[2:1]);
      cfgAlign    <= wrLow[3];
      cfgIrqEn    <= wrLow[4];
      cfgLastSlot <= wrLow[SLOT_LSB +: SLOT_W];
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CFG:    regRdData = DATA_W'({cfgLastSlot, cfgIrqEn, cfgAlign, cfgLen, cfgEn});
      ADDR_STATUS: regRdData = DATA_W'({underrunFlag, emptyFlag});
      default: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (regAddr == ADDR_W'(int'(ADDR_MASK_LO) + b))
            regRdData = DATA_W'(maskBank[b]);
        end
      end
    endcase
  end

  // ---------------- two-stage status pipeline ----------------
  logic [1:0] pipeVld;
  logic [1:0] pipeNull;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeVld  <= '0;
      pipeNull <= '0;
    end else begin
      pipeVld  <= {pipeVld[0], anyWr};
      pipeNull <= {pipeNull[0], nullWr};
    end
  end

  // ---------------- slot sequencer ----------------
  logic              active;
  logic [SLOT_W-1:0] slotIdx;
  logic [BIT_W-1:0]  bitCnt;
  logic              nullPend;
  logic              clrArm;

  logic              tickNow, startSlot, endFrame, advanceBit;
  logic [SLOT_W-1:0] nextSlot;
  logic              slotOn, consume, underrunEv, sendWord;

  always_comb begin
    tickNow    = bitTick && cfgEn;
    startSlot  = 1'b0;
    endFrame   = 1'b0;
    advanceBit = 1'b0;
    nextSlot   = slotIdx;
    if (tickNow) begin
      if (frameSync) begin
        startSlot = 1'b1;
        nextSlot  = '0;
      end else if (active) begin
        if (bitCnt == lastBitOf(cfgLen)) begin
          if (slotIdx == cfgLastSlot) begin
            endFrame = 1'b1;
          end else begin
            startSlot = 1'b1;
            nextSlot  = slotIdx + 1'b1;
          end
        end else begin
          advanceBit = 1'b1;
        end
      end
    end
    slotOn     = maskFlat[nextSlot];
    consume    = startSlot && slotOn && !emptyFlag;
    underrunEv = startSlot && slotOn && emptyFlag;
    sendWord   = consume && !nullPend;
  end

  always_comb begin
    strobe.loadNew    = sendWord;
    strobe.reloadLast = underrunEv;
    strobe.shiftBit   = advanceBit;
    strobe.driveOn    = sendWord || underrunEv;
    strobe.driveOff   = !cfgEn || endFrame || (startSlot && !(sendWord || underrunEv));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      slotIdx <= '0;
      bitCnt  <= '0;
    end else if (!cfgEn) begin
      active  <= 1'b0;
      slotIdx <= '0;
      bitCnt  <= '0;
    end else if (startSlot) begin
      active  <= 1'b1;
      slotIdx <= nextSlot;
      bitCnt  <= '0;
    end else if (endFrame) begin
      active  <= 1'b0;
    end else if (advanceBit) begin
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  // ---------------- flags ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emptyFlag <= 1'b1;
      nullPend  <= 1'b0;
    end else if (pipeVld[1]) begin
      emptyFlag <= 1'b0;
      nullPend  <= pipeNull[1];
    end else if (consume) begin
      emptyFlag <= 1'b1;
      nullPend  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      underrunFlag <= 1'b0;
      clrArm       <= 1'b0;
    end else if (underrunEv) begin
      underrunFlag <= 1'b1;
      clrArm       <= 1'b0;
    end else if (pipeVld[1]) begin
      if (clrArm) underrunFlag <= 1'b0;
      clrArm <= 1'b0;
    end else if (statusRd && underrunFlag) begin
      clrArm <= 1'b1;
    end
  end

  assign irq = cfgIrqEn && emptyFlag;

endmodule

// File: rtl/tdm_tx_dp.sv
module tdm_tx_dp
  import tdm_tx_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int ALIGN_MSB = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              holdWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgAlign,
  input  wordLenE           cfgLen,
  input  dpStrobeT          strobe,
  output logic              sdOut,
  output logic              sdOe
);

  localparam int ALIGN_SHIFT = DATA_W - 1 - ALIGN_MSB;

  logic [DATA_W-1:0] dataHold;
  logic [DATA_W-1:0] lastWord;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] aligned;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       dataHold <= '0;
    else if (holdWr) dataHold <= wrData;
  end

  // left-justify the selected field so the shifter always sends its top bit
  assign aligned = (cfgAlign && (cfgLen != LEN_24)) ? (dataHold << ALIGN_SHIFT) : dataHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastWord <= '0;
      shiftReg <= '0;
    end else if (strobe.loadNew) begin
      lastWord <= aligned;
      shiftReg <= aligned;
    end else if (strobe.reloadLast) begin
      shiftReg <= lastWord;
    end else if (strobe.shiftBit) begin
      shiftReg <= shiftReg << 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sdOe <= 1'b0;
    else if (strobe.driveOff) sdOe <= 1'b0;
    else if (strobe.driveOn)  sdOe <= 1'b1;
  end

  assign sdOut = shiftReg[DATA_W-1];

endmodule

// File: rtl/tdm_net_tx.sv
module tdm_net_tx
  import tdm_tx_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int MASK_W    = 16,
  parameter int MAX_SLOTS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              bitTick,
  input  logic              frameSync,
  output logic              sdOut,
  output logic              sdOe,
  output logic              irq
);

  dpStrobeT strobe;
  logic     holdWr;
  logic     cfgEn, cfgIrqEn, cfgAlign;
  wordLenE  cfgLen;
  logic     emptyFlag, underrunFlag;

  tdm_tx_ctrl #(
    .DATA_W(DATA_W), .MASK_W(MASK_W), .MAX_SLOTS(MAX_SLOTS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .wrLow(regWrData[MASK_W-1:0]), .regRdData(regRdData),
    .bitTick(bitTick), .frameSync(frameSync),
    .strobe(strobe), .holdWr(holdWr),
    .cfgEn(cfgEn), .cfgIrqEn(cfgIrqEn), .cfgAlign(cfgAlign), .cfgLen(cfgLen),
    .emptyFlag(emptyFlag), .underrunFlag(underrunFlag), .irq(irq)
  );

  tdm_tx_dp #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .holdWr(holdWr), .wrData(regWrData),
    .cfgAlign(cfgAlign), .cfgLen(cfgLen),
    .strobe(strobe), .sdOut(sdOut), .sdOe(sdOe)
  );

endmodule

// File: rtl/tdm_net_tx_chk.sv
module tdm_net_tx_chk
  import tdm_tx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              bitTick,
  input logic              sdOut,
  input logic              sdOe,
  input logic              irq,
  input logic              cfgEn,
  input logic              cfgIrqEn,
  input logic              emptyFlag,
  input logic              underrunFlag
);

  logic wordWr;
  assign wordWr = regWrEn && (regAddr == ADDR_DATA || regAddr == ADDR_NULL);

  AST_EMPTY_FALLS_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(emptyFlag) |-> $past(wordWr, 3)); // R3

  AST_PIN_QUIET_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEn && !bitTick) |=> ($stable(sdOut) && $stable(sdOe))); // R4

  AST_DRIVE_STARTS_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdOe) |-> $past(bitTick)); // R4

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(bitTick) || !$past(cfgIrqEn))); // R9

  AST_UNDERRUN_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(underrunFlag) |-> $past(wordWr, 3)); // R11

  AST_DISABLED_RELEASES_PIN: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |=> !sdOe); // R12

endmodule

bind tdm_net_tx tdm_net_tx_chk chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .bitTick(bitTick), .sdOut(sdOut), .sdOe(sdOe), .irq(irq),
  .cfgEn(cfgEn), .cfgIrqEn(cfgIrqEn),
  .emptyFlag(emptyFlag), .underrunFlag(underrunFlag)
);

// File: tb/tdm_net_tx_tb_top.sv
module tdm_net_tx_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [23:0] regWrData = '0;
  logic [23:0] regRdData;
  logic        bitTick = 1'b0;
  logic        frameSync = 1'b0;
  logic        sdOut, sdOe, irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_net_tx dut_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .bitTick(bitTick), .frameSync(frameSync),
    .sdOut(sdOut), .sdOe(sdOe), .irq(irq)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // cfg: bit0 en, bits2:1 len, bit3 align, bit4 irq enable, bits9:5 last slot
  task automatic setCfg(input bit en, input logic [1:0] len, input bit al, input bit ie,
                        input logic [4:0] last);
    wr(3'd4, {14'd0, last, ie, al, len, en});
  endtask

  task automatic tick(input bit fs, output logic b, output logic o);
    @(negedge clk);
    bitTick = 1'b1; frameSync = fs;
    @(negedge clk);
    bitTick = 1'b0; frameSync = 1'b0;
    b = sdOut; o = sdOe;
    repeat (2) @(negedge clk);
  endtask

  task automatic runSlot(input int len, input bit fs, output logic [23:0] word,
                         output logic oeAll, output logic oeAny);
    logic b, o;
    word = '0; oeAll = 1'b1; oeAny = 1'b0;
    for (int i = 0; i < len; i++) begin
      tick(fs && (i == 0), b, o);
      word  = {word[22:0], b};
      oeAll = oeAll & o;
      oeAny = oeAny | o;
    end
  endtask

  task automatic testReset();
    logic [23:0] d;
    chk("R1 sdOe after reset", {23'd0, sdOe}, 24'd0);
    chk("R1 irq after reset", {23'd0, irq}, 24'd0);
    rd(3'd5, d); chk("R1 status after reset", d, 24'h000001);
    rd(3'd4, d); chk("R1 config after reset", d, 24'h000000);
    rd(3'd2, d); chk("R1 mask lo after reset", d, 24'h000000);
  endtask

  task automatic testRegs();
    logic [23:0] d;
    wr(3'd2, 24'hFFA5C3);
    rd(3'd2, d); chk("R2 mask lo readback", d, 24'h00A5C3);
    wr(3'd3, 24'h123456);
    rd(3'd3, d); chk("R2 mask hi readback", d, 24'h003456);
    rd(3'd0, d); chk("R2 data reg reads zero", d, 24'h000000);
    rd(3'd1, d); chk("R2 null reg reads zero", d, 24'h000000);
  endtask

  task automatic testLatency();
    setCfg(1'b0, 2'd0, 1'b0, 1'b1, 5'd1);
    chk("R9 irq while empty and enabled", {23'd0, irq}, 24'd1);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd0; regWrData = 24'hA51234;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 3'd5; regRdEn = 1'b1;
    #1 chk("R3 empty one cycle after write", regRdData, 24'h000001);
    @(negedge clk);
    #1 chk("R3 empty two cycles after write", regRdData, 24'h000001);
    @(negedge clk);
    #1 chk("R3 empty clear after latency", regRdData, 24'h000000);
    chk("R9 irq low once filled", {23'd0, irq}, 24'd0);
    regRdEn = 1'b0;
  endtask

  task automatic testBasicFrame();
    logic [23:0] w, d; logic oa, on, b, o;
    wr(3'd2, 24'h000003); wr(3'd3, 24'h000000);
    setCfg(1'b1, 2'd0, 1'b0, 1'b1, 5'd1);
    runSlot(8, 1'b1, w, oa, on);
    chk("R4 R5 slot0 8-bit word", w, 24'h0000A5);
    chk("R7 slot0 driven", {23'd0, oa}, 24'd1);
    rd(3'd5, d); chk("R7 consumed slot sets empty", d, 24'h000001);
    chk("R9 irq after consume", {23'd0, irq}, 24'd1);
    wr(3'd0, 24'h3C0000);
    runSlot(8, 1'b0, w, oa, on);
    chk("R4 slot1 follows slot0", w, 24'h00003C);
    chk("R4 slot1 driven", {23'd0, oa}, 24'd1);
    tick(1'b0, b, o); chk("R4 pin released after last slot", {23'd0, o}, 24'd0);
    tick(1'b0, b, o); chk("R4 pin stays released without sync", {23'd0, o}, 24'd0);
  endtask

  task automatic testLengths();
    logic [23:0] w; logic oa, on, b, o;
    setCfg(1'b1, 2'd1, 1'b1, 1'b0, 5'd0);
    wr(3'd0, 24'h12ABCD);
    runSlot(12, 1'b1, w, oa, on);
    chk("R5 R6 12-bit msb at bit15", w, 24'h000ABC);
    tick(1'b0, b, o);
    setCfg(1'b1, 2'd2, 1'b0, 1'b0, 5'd0);
    wr(3'd0, 24'hBEEF12);
    runSlot(16, 1'b1, w, oa, on);
    chk("R5 R6 16-bit msb at bit23", w, 24'h00BEEF);
    tick(1'b0, b, o);
    setCfg(1'b1, 2'd3, 1'b1, 1'b0, 5'd0);
    wr(3'd0, 24'h5A3C96);
    runSlot(24, 1'b1, w, oa, on);
    chk("R6 24-bit ignores align", w, 24'h5A3C96);
    chk("R5 24-bit driven whole slot", {23'd0, oa}, 24'd1);
    tick(1'b0, b, o);
  endtask

  task automatic testMaskAndNull();
    logic [23:0] w, d; logic oa, on, b, o;
    setCfg(1'b1, 2'd0, 1'b0, 1'b0, 5'd1);
    wr(3'd2, 24'h000002);
    wr(3'd0, 24'h770000);
    runSlot(8, 1'b1, w, oa, on);
    chk("R7 masked-out slot tri-stated", {23'd0, on}, 24'd0);
    rd(3'd5, d); chk("R7 masked-out slot keeps word", d, 24'h000000);
    runSlot(8, 1'b0, w, oa, on);
    chk("R7 next enabled slot sends kept word", w, 24'h000077);
    tick(1'b0, b, o);
    wr(3'd2, 24'h000003);
    wr(3'd1, 24'h0000FF);
    runSlot(8, 1'b1, w, oa, on);
    chk("R8 null slot tri-stated", {23'd0, on}, 24'd0);
    rd(3'd5, d); chk("R8 null slot sets empty", d, 24'h000001);
    wr(3'd0, 24'h990000);
    runSlot(8, 1'b0, w, oa, on);
    chk("R8 slot after null sends data", w, 24'h000099);
    tick(1'b0, b, o);
  endtask

  task automatic testUnderrun();
    logic [23:0] w, d; logic oa, on, b, o;
    setCfg(1'b1, 2'd0, 1'b0, 1'b0, 5'd0);
    runSlot(8, 1'b1, w, oa, on);
    chk("R10 underrun resends previous word", w, 24'h000099);
    chk("R10 underrun slot driven", {23'd0, oa}, 24'd1);
    tick(1'b0, b, o);
    wr(3'd0, 24'h440000);
    rd(3'd5, d); chk("R11 write alone keeps underrun", d, 24'h000002);
    wr(3'd0, 24'h550000);
    rd(3'd5, d); chk("R11 read then write clears underrun", d, 24'h000000);
    runSlot(8, 1'b1, w, oa, on);
    chk("R11 latest word sent after clear", w, 24'h000055);
    tick(1'b0, b, o);
  endtask

  task automatic testDisable();
    logic [23:0] w; logic oa, on;
    setCfg(1'b0, 2'd0, 1'b0, 1'b0, 5'd0);
    wr(3'd0, 24'h660000);
    runSlot(8, 1'b1, w, oa, on);
    chk("R12 disabled pin never driven", {23'd0, on}, 24'd0);
  endtask

  task automatic testHighBank();
    logic [23:0] w; logic oa, on, b, o, anyLow;
    setCfg(1'b1, 2'd0, 1'b0, 1'b0, 5'd16);
    wr(3'd2, 24'h000000); wr(3'd3, 24'h000001);
    wr(3'd0, 24'hC30000);
    anyLow = 1'b0;
    for (int s = 0; s < 16; s++) begin
      runSlot(8, s == 0, w, oa, on);
      anyLow = anyLow | on;
    end
    chk("R13 slots 0..15 tri-stated", {23'd0, anyLow}, 24'd0);
    runSlot(8, 1'b0, w, oa, on);
    chk("R13 slot16 word from bank two", w, 24'h0000C3);
    chk("R13 slot16 driven", {23'd0, oa}, 24'd1);
    tick(1'b0, b, o); chk("R13 frame ends after slot16", {23'd0, o}, 24'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R4 actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testLatency();
    testBasicFrame();
    testLengths();
    testMaskAndNull();
    testUnderrun();
    testDisable();
    testHighBank();
    finishRun();
  end

endmodule